// File: doc/BRIEF.md
# Noise Spike Link Quality Detector

This block judges the quality of a received link by watching the raw data bit before any data filtering. Noise appears there as short glitches, which are pulses much shorter than a data bit. The block measures every pulse of either polarity in sample clocks. It counts those that are shorter than half the nominal bit period over an observation window of sixteen bit periods. At the end of each window it compares the count with a 3-bit limit.

The single output is a registered good-quality flag. It is set when the window held no more glitches than the limit, and cleared otherwise. It changes only at window boundaries, so downstream logic sees one verdict per window. Signal amplitude plays no part in the decision.

Top module: `spike_quality_det`

## Requirements
- R1: After reset `good_o` is 0, and it stays 0 until the first window completes.
- R2: A pulse of either polarity counts as a glitch when it is bounded by a transition at each end and lasts fewer than floor(`bit_period_i`/2) samples. A pulse of floor(`bit_period_i`/2) samples or more does not count.
- R3: The first window starts at the first rising clock edge after `rst_ni` is released. Each window is 16 x `bit_period_i` clock samples long, and windows follow each other with no gap.
- R4: At the last sample of each window, `good_o` is loaded with 1 when the glitch count for that window is no greater than `thresh_i`, and with 0 otherwise.
- R5: `good_o` is registered and changes only on the clock edge that ends a window.
- R6: The glitch counter saturates at 15. A window with 16 or more glitches always reports poor quality, even when `thresh_i` = 7.
- R7: When `thresh_i` = 0, a single glitch in a window clears `good_o` at that window's end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 1 | Raw unfiltered data bit, one sample per clock |
| bit_period_i | input | PER_W (8) | Nominal bit period in samples, held constant between resets |
| thresh_i | input | THR_W (3) | Highest glitch count still reported as good |
| good_o | output | 1 | Good-quality flag, updated at each window end |

## Verification
The hardest case to reach from the ports is the counter at saturation. Only a window with more than fifteen glitches gets there, and a counter that wraps instead of saturating would then report good quality at the top threshold. The bench places windows of sixteen and twenty one-sample glitches, spaced by gaps exactly half a bit long, where the 3-bit limit cannot hide a wrap. It stays aligned to the window grid from reset release, so every glitch falls inside a known window. Pulses exactly half a bit long, of both polarities, probe the glitch boundary.

// File: rtl/dq_pkg.sv
package dq_pkg;
  parameter int unsigned DQ_WIN_BITS = 16;
  parameter int unsigned DQ_CNT_W    = 4;
  parameter int unsigned DQ_THR_W    = 3;
endpackage

// File: rtl/dq_pulse_meter.sv
module dq_pulse_meter #(
  parameter int unsigned PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic [PER_W-1:0] bit_period_i,
  output logic             spike_o
);
  logic             d_q, seen_q, spike_q;
  logic [PER_W-1:0] run_q;
  logic [PER_W-1:0] half_w;
  logic             edge_w;

  assign half_w = bit_period_i >> 1;
  assign edge_w = data_i ^ d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q     <= 1'b0;
      seen_q  <= 1'b0;
      run_q   <= '0;
      spike_q <= 1'b0;
    end else begin
      d_q     <= data_i;
      // first run after reset has no leading edge: never a glitch
      spike_q <= edge_w && seen_q && (run_q < half_w);
      if (edge_w) begin
        run_q  <= {{(PER_W-1){1'b0}}, 1'b1};
        seen_q <= 1'b1;
      end else if (run_q != '1) begin
        run_q  <= run_q + 1'b1;
      end
    end
  end

  assign spike_o = spike_q;

  // R2
  spike_needs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spike_q |-> (d_q != $past(d_q)));
endmodule

// File: rtl/dq_window_timer.sv
module dq_window_timer #(
  parameter int unsigned PER_W    = 8,
  parameter int unsigned WIN_BITS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] bit_period_i,
  output logic             win_end_o
);
  localparam int unsigned BIT_W = (WIN_BITS > 1) ? $clog2(WIN_BITS) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WIN_BITS - 1);
  localparam logic [PER_W-1:0] ONE      = PER_W'(1);

  logic [PER_W-1:0] samp_q, per_last_w;
  logic [BIT_W-1:0] bit_q;
  logic             samp_last_w;

  // a zero period behaves as one sample per bit
  assign per_last_w  = (bit_period_i == '0) ? '0 : bit_period_i - ONE;
  assign samp_last_w = samp_q >= per_last_w;
  assign win_end_o   = samp_last_w && (bit_q == BIT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      bit_q  <= '0;
    end else if (samp_last_w) begin
      samp_q <= '0;
      bit_q  <= win_end_o ? '0 : bit_q + 1'b1;
    end else begin
      samp_q <= samp_q + ONE;
    end
  end

  // R3
  window_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_o |=> (samp_q == '0 && bit_q == '0));
endmodule

// File: rtl/dq_spike_counter.sv
module dq_spike_counter #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned THR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spike_i,
  input  logic             win_end_i,
  input  logic [THR_W-1:0] thresh_i,
  output logic             good_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_next_w, thr_ext_w;
  logic             good_q;

  assign thr_ext_w  = {{(CNT_W-THR_W){1'b0}}, thresh_i};
  assign cnt_next_w = (spike_i && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else if (win_end_i) begin
      cnt_q  <= '0;
      good_q <= (cnt_next_w <= thr_ext_w);
    end else begin
      cnt_q  <= cnt_next_w;
    end
  end

  assign good_o = good_q;

  // R6
  cnt_saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !win_end_i) |=> (cnt_q == CNT_MAX));
  // R5
  good_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> $stable(good_q));
  // R7
  zero_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end_i && thresh_i == '0 && cnt_q != '0) |=> !good_q);
endmodule

// File: rtl/spike_quality_det.sv
module spike_quality_det
  import dq_pkg::*;
#(
  parameter int unsigned PER_W    = 8,
  parameter int unsigned WIN_BITS = DQ_WIN_BITS,
  parameter int unsigned CNT_W    = DQ_CNT_W,
  parameter int unsigned THR_W    = DQ_THR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic [PER_W-1:0] bit_period_i,
  input  logic [THR_W-1:0] thresh_i,
  output logic             good_o
);
  logic spike_w, win_end_w;

  dq_pulse_meter #(.PER_W(PER_W)) u_meter (
    .clk_i, .rst_ni, .data_i, .bit_period_i, .spike_o(spike_w)
  );

  dq_window_timer #(.PER_W(PER_W), .WIN_BITS(WIN_BITS)) u_timer (
    .clk_i, .rst_ni, .bit_period_i, .win_end_o(win_end_w)
  );

  dq_spike_counter #(.CNT_W(CNT_W), .THR_W(THR_W)) u_count (
    .clk_i, .rst_ni, .spike_i(spike_w), .win_end_i(win_end_w),
    .thresh_i, .good_o
  );
endmodule

// File: tb/tb_spike_quality_det.sv
module tb_spike_quality_det;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       data_i = 1'b0;
  logic [7:0] bit_period_i = 8'd8;
  logic [2:0] thresh_i = 3'd0;
  logic       good_o;

  int n_chk = 0;
  int n_bad = 0;
  logic prev_good;

  spike_quality_det dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: good_o=%0b expected %0b", req, act, exp);
    end
  endtask

  // enter reset at a negedge, release at a later negedge
  task automatic do_reset(int p);
    rst_ni = 1'b0;
    data_i = 1'b0;
    bit_period_i = 8'(p);
    repeat (3) @(negedge clk_i);
    chk("R1", good_o, 1'b0);
    rst_ni = 1'b1;
  endtask

  // one window of 16*p samples: n pulses of length len against baseline base
  task automatic run_window(int p, int n, int len, int gap, logic base, int thr,
                            logic exp, string req, bit first);
    int win = 16 * p;
    thresh_i = 3'(thr);
    for (int s = 0; s < win; s++) begin
      logic v = base;
      if (s == win / 2) chk(first ? "R1" : "R5", good_o, prev_good);
      if (s >= 4) begin
        int o = (s - 4) % (len + gap);
        int k = (s - 4) / (len + gap);
        if (k < n && o < len) v = ~base;
      end
      data_i = v;
      @(negedge clk_i);
    end
    chk(req, good_o, exp);
    prev_good = good_o;
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: good_o=%0b expected completion", good_o);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // bit period 8: glitch is shorter than 4 samples
    do_reset(8);
    prev_good = 1'b0;
    run_window(8, 5, 1, 5, 1'b0, 7, 1'b1, "R4", 1'b1);
    // sweep spike count against threshold, both polarities (R4, R2, R3)
    for (int thr = 0; thr < 8; thr++)
      for (int n = 0; n < 10; n++)
        run_window(8, n, 1 + (n % 3), 5, logic'(n[0] ^ thr[0]), thr,
                   logic'(n <= thr), (thr == 0 && n == 1) ? "R7" : "R4", 1'b0);
    // pulses of exactly half a bit are not glitches (R2)
    run_window(8, 12, 4, 4, 1'b0, 0, 1'b1, "R2", 1'b0);
    run_window(8, 12, 4, 4, 1'b1, 0, 1'b1, "R2", 1'b0);
    run_window(8, 1, 3, 5, 1'b1, 0, 1'b0, "R7", 1'b0);
    run_window(8, 0, 1, 5, 1'b1, 0, 1'b1, "R7", 1'b0);
    // saturation: 16 and 20 glitches with the largest threshold (R6)
    run_window(8, 16, 1, 4, 1'b0, 7, 1'b0, "R6", 1'b0);
    run_window(8, 7, 1, 4, 1'b0, 7, 1'b1, "R4", 1'b0);
    run_window(8, 20, 1, 4, 1'b1, 7, 1'b0, "R6", 1'b0);
    run_window(8, 15, 1, 4, 1'b0, 7, 1'b0, "R6", 1'b0);

    // bit period 4: window of 64 samples, glitch shorter than 2 (R3, R2)
    do_reset(4);
    prev_good = 1'b0;
    run_window(4, 2, 1, 2, 1'b0, 2, 1'b1, "R3", 1'b1);
    for (int n = 0; n < 6; n++)
      run_window(4, n, 1, 2, logic'(n[0]), 3, logic'(n <= 3), "R3", 1'b0);
    run_window(4, 10, 2, 2, 1'b0, 0, 1'b1, "R2", 1'b0);
    run_window(4, 16, 1, 2, 1'b1, 7, 1'b0, "R6", 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule